// File: doc/BRIEF.md
# Pipeline Precise Exception Controller

This block keeps exceptions and interrupts precise in a five-stage in-order pipeline. It holds the per-stage slot registers for decode, execute, memory and writeback. Each slot carries a valid bit, a PC, an exception flag, a cause code and a return marker. Any stage may flag a fault on the instruction it holds. The flag travels with that instruction and has no effect until the instruction arrives at writeback. There the block saves the PC of the faulting instruction, sends fetch to a fixed handler address, enters supervisor mode with interrupts disabled, and empties every younger slot.

While interrupts are enabled, an external interrupt request turns the instruction being fetched into a no-op that is flagged as faulting. That no-op then travels down the pipe like any other fault. The request is a level signal. If the no-op is flushed, the next fetch carries a new one. An instruction that decode marks as a return from exception goes back to the saved PC at writeback, restores user mode and re-enables interrupts. Store enables in the memory stage are held off for any instruction whose result must not become visible.

Top module: `pexc_ctrl`

## Requirements
- R1: After reset, the block is in user mode (sup_mode=0) with interrupts enabled (int_en=1), epc=0 and cause=0. redirect, retire_valid and store_en are all low, even when mem_store is high.
- R2: An instruction offered with fetch_valid in cycle N, with no fault and no flush, shows retire_valid=1 and retire_pc equal to its fetch PC in cycle N+4.
- R3: A flagged instruction has effect only when it is in writeback. In that cycle, redirect=1 and redirect_pc=VECTOR. From the next cycle, epc holds its PC and cause holds its code.
- R4: An instruction keeps the first cause detected on it. A cause raised on the same instruction in a later stage is ignored.
- R5: When an older instruction faults in a later stage than a younger one, the older instruction's fault is the one taken at writeback.
- R6: When an exception or return is taken, every instruction in decode, execute and memory is discarded, and so is the instruction fetched in that cycle. None of them later retires or raises an exception.
- R7: Taking an exception sets sup_mode=1 and int_en=0 from the next cycle.
- R8: If irq=1 and int_en=1, a valid fetch slot becomes a faulting no-op with cause 0 and the PC of that fetch. This takes precedence over a fetch fault in the same slot. While int_en=0, irq has no effect and fetched instructions retire normally.
- R9: The cause codes are: fetch_fault gives 1, dec_illegal gives 2, ex_ovf gives 3, mem_fault gives 4. A fault raised while the stage holds no valid instruction is ignored.
- R10: An instruction marked with dec_rte in decode that reaches writeback without a fault drives redirect=1 with redirect_pc equal to epc. It flushes the younger instructions. From the next cycle, sup_mode=0 and int_en=1.
- R11: store_en is 1 only when the memory stage holds a valid instruction with no fault, mem_store=1, mem_fault=0, and no exception or return is being taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | 32 | PC of the fetched instruction |
| fetch_fault | input | 1 | Fetch translation fault on this fetch |
| irq | input | 1 | Level external interrupt request |
| dec_illegal | input | 1 | Decode found an illegal instruction |
| dec_rte | input | 1 | Decode found a return from exception |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_fault | input | 1 | Data translation fault in memory stage |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Restart address (handler vector or saved PC) |
| retire_valid | output | 1 | Writeback instruction commits normally |
| retire_pc | output | 32 | PC of the writeback instruction |
| store_en | output | 1 | Memory-stage store may write |
| epc | output | 32 | Saved exception PC |
| cause | output | 3 | Code of the last exception taken |
| sup_mode | output | 1 | Supervisor mode flag |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The properties assume that each stage fault input describes the instruction currently in that stage, and that fetch follows redirect. They tolerate fault inputs that arrive while a slot is empty, because the design is required to ignore them. The random stimulus drives every fault input on its own at a low rate, in both occupied and empty cycles. It holds irq in bursts and marks returns often enough that interrupts come back on. A bench model of the pipeline gives the expected value of every output in every cycle. Directed cases separately cover ordering, double faults, the interrupt level, return and store suppression.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
    localparam int PCW  = 32;
    localparam int CW   = 3;
    localparam int NSTG = 4;

    typedef enum logic [CW-1:0] {
        CS_IRQ     = 3'd0,
        CS_IFAULT  = 3'd1,
        CS_ILLEGAL = 3'd2,
        CS_OVF     = 3'd3,
        CS_DFAULT  = 3'd4
    } cause_e;

    typedef struct packed {
        logic           valid;
        logic           exc;
        cause_e         cause;
        logic           rte;
        logic [PCW-1:0] pc;
    } slot_t;

    // cause raised by the stage feeding slot k+1
    function automatic cause_e stage_cause(input int k);
        case (k)
            1:       return CS_ILLEGAL;
            2:       return CS_OVF;
            3:       return CS_DFAULT;
            default: return CS_IFAULT;
        endcase
    endfunction
endpackage

// File: rtl/pexc_inject.sv
module pexc_inject
    import pexc_pkg::*;
(
    input  logic           fetch_valid,
    input  logic [PCW-1:0] fetch_pc,
    input  logic           fetch_fault,
    input  logic           irq,
    input  logic           int_en,
    output slot_t          ent
);
    always_comb begin
        ent       = '0;
        ent.valid = fetch_valid;
        ent.pc    = fetch_pc;
        ent.cause = CS_IRQ;
        if (fetch_valid && irq && int_en) begin
            ent.exc   = 1'b1;
            ent.cause = CS_IRQ;
        end else if (fetch_valid && fetch_fault) begin
            ent.exc   = 1'b1;
            ent.cause = CS_IFAULT;
        end
    end
endmodule

// File: rtl/pexc_stage.sv
module pexc_stage
    import pexc_pkg::*;
#(
    parameter cause_e RAISE_CODE = CS_IFAULT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t din,
    input  logic  raise,
    input  logic  rte_mark,
    output slot_t dout
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            dout <= '0;
        end else begin
            dout <= din;
            if (din.valid && !din.exc && raise) begin
                dout.exc   <= 1'b1;
                dout.cause <= RAISE_CODE;
            end
            if (din.valid && rte_mark) begin
                dout.rte <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pexc_commit.sv
module pexc_commit
    import pexc_pkg::*;
#(
    parameter logic [PCW-1:0] VECTOR = 32'h0000_0080
) (
    input  logic           clk,
    input  logic           rst,
    input  slot_t          wb,
    output logic           take,
    output logic           ret,
    output logic           redirect,
    output logic [PCW-1:0] redirect_pc,
    output logic           retire_valid,
    output logic [PCW-1:0] retire_pc,
    output logic [PCW-1:0] epc,
    output logic [CW-1:0]  cause,
    output logic           sup_mode,
    output logic           int_en
);
    assign take         = wb.valid && wb.exc;
    assign ret          = wb.valid && !wb.exc && wb.rte;
    assign redirect     = take || ret;
    assign redirect_pc  = take ? VECTOR : epc;
    assign retire_valid = wb.valid && !wb.exc;
    assign retire_pc    = wb.pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            cause    <= CS_IRQ;
            sup_mode <= 1'b0;
            int_en   <= 1'b1;
        end else if (take) begin
            epc      <= wb.pc;
            cause    <= wb.cause;
            sup_mode <= 1'b1;
            int_en   <= 1'b0;
        end else if (ret) begin
            sup_mode <= 1'b0;
            int_en   <= 1'b1;
        end
    end
endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
    import pexc_pkg::*;
#(
    parameter logic [PCW-1:0] VECTOR = 32'h0000_0080
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fetch_valid,
    input  logic [PCW-1:0] fetch_pc,
    input  logic           fetch_fault,
    input  logic           irq,
    input  logic           dec_illegal,
    input  logic           dec_rte,
    input  logic           ex_ovf,
    input  logic           mem_store,
    input  logic           mem_fault,
    output logic           redirect,
    output logic [PCW-1:0] redirect_pc,
    output logic           retire_valid,
    output logic [PCW-1:0] retire_pc,
    output logic           store_en,
    output logic [PCW-1:0] epc,
    output logic [CW-1:0]  cause,
    output logic           sup_mode,
    output logic           int_en
);
    // chain[0]=fetch entry, [1]=decode, [2]=execute, [3]=memory, [4]=writeback
    slot_t            chain [NSTG+1];
    logic [NSTG-1:0]  raise_v;
    logic [NSTG-1:0]  rte_v;
    logic             take;
    logic             ret;
    logic             flush;
    logic             wb_exc;
    logic [PCW-1:0]   wb_pc;

    assign raise_v = {mem_fault, ex_ovf, dec_illegal, 1'b0};
    assign rte_v   = {1'b0, 1'b0, dec_rte, 1'b0};
    assign flush   = take || ret;

    pexc_inject u_inj (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .fetch_fault (fetch_fault),
        .irq         (irq),
        .int_en      (int_en),
        .ent         (chain[0])
    );

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        pexc_stage #(.RAISE_CODE(stage_cause(k))) u_stg (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .din      (chain[k]),
            .raise    (raise_v[k]),
            .rte_mark (rte_v[k]),
            .dout     (chain[k+1])
        );
    end

    pexc_commit #(.VECTOR(VECTOR)) u_cmt (
        .clk          (clk),
        .rst          (rst),
        .wb           (chain[NSTG]),
        .take         (take),
        .ret          (ret),
        .redirect     (redirect),
        .redirect_pc  (redirect_pc),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc),
        .epc          (epc),
        .cause        (cause),
        .sup_mode     (sup_mode),
        .int_en       (int_en)
    );

    assign store_en = chain[NSTG-1].valid && !chain[NSTG-1].exc
                      && mem_store && !mem_fault && !flush;

    assign wb_exc = chain[NSTG].valid && chain[NSTG].exc;
    assign wb_pc  = chain[NSTG].pc;
endmodule

// File: rtl/pexc_chk.sv
module pexc_chk
    import pexc_pkg::*;
#(
    parameter logic [PCW-1:0] VECTOR = 32'h0000_0080
) (
    input logic           clk,
    input logic           rst,
    input logic           redirect,
    input logic [PCW-1:0] redirect_pc,
    input logic           retire_valid,
    input logic           store_en,
    input logic           sup_mode,
    input logic           int_en,
    input logic [PCW-1:0] epc,
    input logic [CW-1:0]  cause,
    input logic           wb_exc,
    input logic [PCW-1:0] wb_pc
);
    a_r11_no_store_on_redirect: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !store_en);

    a_r7_mode_on_take: assert property (@(posedge clk) disable iff (rst)
        (redirect && wb_exc) |=> (sup_mode && !int_en));

    a_r3_epc_capture: assert property (@(posedge clk) disable iff (rst)
        (redirect && wb_exc) |=> (epc == $past(wb_pc)));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!redirect && !retire_valid));

    a_r10_return_mode: assert property (@(posedge clk) disable iff (rst)
        (redirect && !wb_exc) |=> (!sup_mode && int_en));

    a_r9_cause_code: assert property (@(posedge clk) disable iff (rst)
        cause <= 3'd4);

    a_r3_vector_target: assert property (@(posedge clk) disable iff (rst)
        (redirect && wb_exc && $stable(epc)) |-> (redirect_pc == VECTOR));
endmodule

bind pexc_ctrl pexc_chk #(.VECTOR(VECTOR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .redirect     (redirect),
    .redirect_pc  (redirect_pc),
    .retire_valid (retire_valid),
    .store_en     (store_en),
    .sup_mode     (sup_mode),
    .int_en       (int_en),
    .epc          (epc),
    .cause        (cause),
    .wb_exc       (wb_exc),
    .wb_pc        (wb_pc)
);

// File: tb/sim_pexc_ctrl.sv
module sim_pexc_ctrl;
    import pexc_pkg::*;
    localparam logic [31:0] VEC = 32'h0000_0080;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic fetch_valid = 0, fetch_fault = 0, irq = 0, dec_illegal = 0, dec_rte = 0;
    logic ex_ovf = 0, mem_store = 0, mem_fault = 0;
    logic [31:0] fetch_pc = '0;
    logic redirect, retire_valid, store_en, sup_mode, int_en;
    logic [31:0] redirect_pc, retire_pc, epc;
    logic [2:0] cause;

    pexc_ctrl #(.VECTOR(VEC)) u0 (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_fault(fetch_fault), .irq(irq), .dec_illegal(dec_illegal),
        .dec_rte(dec_rte), .ex_ovf(ex_ovf), .mem_store(mem_store),
        .mem_fault(mem_fault), .redirect(redirect), .redirect_pc(redirect_pc),
        .retire_valid(retire_valid), .retire_pc(retire_pc), .store_en(store_en),
        .epc(epc), .cause(cause), .sup_mode(sup_mode), .int_en(int_en)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference pipeline: index 0 decode .. 3 writeback
    bit          mv [4];
    bit          mexc [4];
    bit          mrte [4];
    logic [31:0] mpc [4];
    logic [2:0]  mcs [4];
    logic [31:0] m_epc;
    logic [2:0]  m_cause;
    bit          m_sup, m_ie;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic bit m_take(); return mv[3] && mexc[3]; endfunction
    function automatic bit m_ret();  return mv[3] && !mexc[3] && mrte[3]; endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            mv[k] = 0; mexc[k] = 0; mrte[k] = 0; mpc[k] = '0; mcs[k] = '0;
        end
        m_epc = '0; m_cause = '0; m_sup = 0; m_ie = 1;
    endtask

    task automatic compare();
        bit tk, rt, fl, st;
        tk = m_take(); rt = m_ret(); fl = tk || rt;
        st = mv[2] && !mexc[2] && mem_store && !mem_fault && !fl;
        chk("R3 redirect", {31'd0, redirect}, {31'd0, fl});
        if (fl) chk("R3 redirect_pc", redirect_pc, tk ? VEC : m_epc);
        chk("R2 retire_valid", {31'd0, retire_valid}, {31'd0, mv[3] && !mexc[3]});
        if (mv[3] && !mexc[3]) chk("R2 retire_pc", retire_pc, mpc[3]);
        chk("R11 store_en", {31'd0, store_en}, {31'd0, st});
        chk("R7 sup_mode", {31'd0, sup_mode}, {31'd0, m_sup});
        chk("R7 int_en", {31'd0, int_en}, {31'd0, m_ie});
        chk("R3 epc", epc, m_epc);
        chk("R4 cause", {29'd0, cause}, {29'd0, m_cause});
    endtask

    task automatic model_adv();
        bit tk, rt, r;
        tk = m_take(); rt = m_ret();
        if (tk || rt) begin
            if (tk) begin
                m_epc = mpc[3]; m_cause = mcs[3]; m_sup = 1; m_ie = 0;
            end else begin
                m_sup = 0; m_ie = 1;
            end
            for (int k = 0; k < 4; k++) begin
                mv[k] = 0; mexc[k] = 0; mrte[k] = 0; mpc[k] = '0; mcs[k] = '0;
            end
        end else begin
            for (int k = 3; k >= 1; k--) begin
                r = (k == 1) ? dec_illegal : (k == 2) ? ex_ovf : mem_fault;
                mv[k] = mv[k-1]; mpc[k] = mpc[k-1];
                mexc[k] = mexc[k-1]; mcs[k] = mcs[k-1]; mrte[k] = mrte[k-1];
                if (mv[k-1] && !mexc[k-1] && r) begin
                    mexc[k] = 1; mcs[k] = 3'(k + 1);
                end
                if (k == 1 && mv[0] && dec_rte) mrte[1] = 1;
            end
            mv[0] = fetch_valid; mpc[0] = fetch_pc; mrte[0] = 0;
            mexc[0] = 0; mcs[0] = 0;
            if (fetch_valid && irq && m_ie) begin
                mexc[0] = 1; mcs[0] = 3'd0;
            end else if (fetch_valid && fetch_fault) begin
                mexc[0] = 1; mcs[0] = 3'd1;
            end
        end
    endtask

    task automatic clear_in();
        fetch_valid = 0; fetch_fault = 0; dec_illegal = 0; dec_rte = 0;
        ex_ovf = 0; mem_store = 0; mem_fault = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        @(posedge clk);
        model_adv();
        #1;
        clear_in();
    endtask

    task automatic do_reset();
        rst = 1; irq = 0; clear_in();
        repeat (2) @(posedge clk);
        model_reset();
        #1 rst = 0;
    endtask

    task automatic fetch(input logic [31:0] pc);
        fetch_valid = 1; fetch_pc = pc;
    endtask

    int burst;

    initial begin
        // R1 reset state
        do_reset();
        mem_store = 1; #1;
        chk("R1 store_en", {31'd0, store_en}, 32'd0);
        chk("R1 redirect", {31'd0, redirect}, 32'd0);
        chk("R1 retire_valid", {31'd0, retire_valid}, 32'd0);
        chk("R1 sup_mode", {31'd0, sup_mode}, 32'd0);
        chk("R1 int_en", {31'd0, int_en}, 32'd1);
        chk("R1 epc", epc, 32'd0);
        chk("R1 cause", {29'd0, cause}, 32'd0);
        mem_store = 0;

        // R2 / R11 plain instruction, store allowed
        fetch(32'h100); step(); step(); step();
        mem_store = 1; #1;
        chk("R11 store allowed", {31'd0, store_en}, 32'd1);
        step();
        chk("R2 retire_valid", {31'd0, retire_valid}, 32'd1);
        chk("R2 retire_pc", retire_pc, 32'h100);

        // R5 older memory fault beats younger earlier fetch fault
        do_reset();
        fetch(32'h200); step();
        fetch(32'h204); fetch_fault = 1; step();
        step();
        mem_fault = 1; step();
        chk("R5 redirect", {31'd0, redirect}, 32'd1);
        chk("R3 vector", redirect_pc, VEC);
        step();
        chk("R5 cause", {29'd0, cause}, 32'd4);
        chk("R5 epc", epc, 32'h200);
        chk("R6 no younger redirect", {31'd0, redirect}, 32'd0);
        repeat (4) step();
        chk("R6 cause kept", {29'd0, cause}, 32'd4);

        // R4 first cause kept
        do_reset();
        fetch(32'h300); step();
        dec_illegal = 1; step();
        ex_ovf = 1; step();
        step(); step();
        chk("R4 cause", {29'd0, cause}, 32'd2);
        chk("R4 epc", epc, 32'h300);

        // R8 / R7 interrupt injection
        do_reset();
        irq = 1;
        for (int i = 0; i < 4; i++) begin
            fetch(32'h400 + 32'(4 * i)); fetch_fault = 1; step();
        end
        chk("R8 redirect", {31'd0, redirect}, 32'd1);
        fetch(32'h410); step();
        chk("R8 cause", {29'd0, cause}, 32'd0);
        chk("R8 epc", epc, 32'h400);
        chk("R7 sup_mode", {31'd0, sup_mode}, 32'd1);
        chk("R7 int_en", {31'd0, int_en}, 32'd0);
        fetch(32'h500); step();
        step(); step(); step();
        chk("R8 ignored retire", {31'd0, retire_valid}, 32'd1);
        chk("R8 ignored retire_pc", retire_pc, 32'h500);
        chk("R8 ignored redirect", {31'd0, redirect}, 32'd0);
        irq = 0;

        // R10 return from exception
        fetch(32'h600); step();
        dec_rte = 1; step();
        step(); step();
        chk("R10 redirect", {31'd0, redirect}, 32'd1);
        chk("R10 target", redirect_pc, 32'h400);
        step();
        chk("R10 sup_mode", {31'd0, sup_mode}, 32'd0);
        chk("R10 int_en", {31'd0, int_en}, 32'd1);

        // R11 store suppressed while exception taken
        do_reset();
        fetch(32'h700); step();
        fetch(32'h704); step();
        ex_ovf = 1; step();
        step();
        mem_store = 1; #1;
        chk("R11 store blocked", {31'd0, store_en}, 32'd0);
        chk("R11 redirect", {31'd0, redirect}, 32'd1);
        step(); step();
        chk("R9 ovf code", {29'd0, cause}, 32'd3);

        // R9 raises on empty slots ignored, fetch fault code
        do_reset();
        for (int i = 0; i < 5; i++) begin
            dec_illegal = 1; ex_ovf = 1; mem_fault = 1; step();
        end
        chk("R9 no redirect", {31'd0, redirect}, 32'd0);
        chk("R9 sup_mode", {31'd0, sup_mode}, 32'd0);
        fetch(32'h800); fetch_fault = 1; step();
        repeat (4) step();
        chk("R9 ifault code", {29'd0, cause}, 32'd1);
        chk("R9 ifault epc", epc, 32'h800);

        // random phase
        do_reset();
        void'($urandom(32'd20250));
        burst = 0;
        for (int i = 0; i < 4000; i++) begin
            fetch_valid = ($urandom % 4) != 0;
            fetch_pc    = fetch_pc + 32'd4;
            fetch_fault = ($urandom % 40) == 0;
            dec_illegal = ($urandom % 40) == 0;
            dec_rte     = ($urandom % 10) == 0;
            ex_ovf      = ($urandom % 40) == 0;
            mem_fault   = ($urandom % 40) == 0;
            mem_store   = ($urandom % 2) == 0;
            if (burst > 0) burst--;
            else if (($urandom % 50) == 0) burst = 3 + ($urandom % 12);
            irq = (burst > 0);
            step();
        end
        irq = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule